// File: doc/BRIEF.md
# Transceiver Supply and Thermal Guard

This block sits between a bus transceiver's digital core and its pin drivers and decides, every clock cycle, how far the device may take part in bus traffic. It watches two digital supply-good flags (one for the host-facing logic side, one for the line side) and an over-temperature flag. From these it selects one of four modes: host-off, line-off, wake-up wait and running. Each mode sets what the line driver does and what the receive pin shows.

The line-off mode forces the receive pin high, but only after a programmable fail-safe delay. When both supplies come back, the device waits through a programmable restart delay before it drives the line again. Any supply fault during that wait starts the wait over. Over-temperature does not change the mode. It only blocks the driver while the flag is set, and the receive path keeps working.

Both delays are counted in clock cycles. With a 50 MHz clock, the default values correspond to about 6 µs of fail-safe delay and about 300 µs of restart delay.

Top module: `xcvr_safety_ctrl`

## Requirements
- R1: While `rst_n` is low, the block is in host-off: `bus_drive_dom`=0, `bus_float`=0, `rxd_out`=1, `rxd_oe`=0.
- R2: In the running mode, `bus_drive_dom` is 1 (drive dominant) exactly when `tx_bit` is 0 and `hot_flag` is 0, and `bus_float` is 0 (line biased recessive).
- R3: In the running mode, `rxd_oe` is 1 and `rxd_out` equals `bus_rx_bit` in the same cycle (0 = dominant, 1 = recessive).
- R4: The first rising edge that samples `logic_pwr_ok`=0 puts the block in host-off, whatever `bus_pwr_ok` is: driver off, line biased recessive (`bus_float`=0), `rxd_oe`=0.
- R5: The first rising edge that samples `logic_pwr_ok`=1 and `bus_pwr_ok`=0 puts the block in line-off: `bus_float`=1, `bus_drive_dom`=0, `rxd_oe`=1.
- R6: In line-off, `rxd_out` follows `bus_rx_bit` after the entry edge and the next FAILSAFE_CYC-1 edges. From the FAILSAFE_CYC-th edge after entry it is held at 1.
- R7: The first edge that samples both supply flags at 1 after a fault enters the wake-up wait: driver off, `bus_float`=0, `rxd_out`=1, `rxd_oe`=1. The wait lasts RECOVER_CYC+1 cycles, and the running mode starts at the edge after that.
- R8: A supply fault during the wake-up wait ends it. When the supplies are good again, the full wait starts over from its new entry edge.
- R9: `hot_flag`=1 forces `bus_drive_dom`=0 in the same cycle, while `bus_float` stays 0 and `rxd_out` still mirrors the bus. When the flag clears, driving resumes in the same cycle with no wait, and the flag can trip again any number of times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| logic_pwr_ok | input | 1 | Host-side supply good |
| bus_pwr_ok | input | 1 | Line-side supply good |
| hot_flag | input | 1 | Over-temperature present |
| tx_bit | input | 1 | Transmit bit from host, 0 = dominant |
| bus_rx_bit | input | 1 | Raw received line bit, 0 = dominant |
| bus_drive_dom | output | 1 | 1 = drive the line dominant |
| bus_float | output | 1 | 1 = line pins high impedance, no recessive bias |
| rxd_out | output | 1 | Value for the receive pin |
| rxd_oe | output | 1 | Receive pin output enable, 0 = tri-state |

## Verification
The bench checks both delay boundaries on the exact cycle. A fail-safe counter that is off by one shows up as `rxd_out` going high one edge early or one edge late. A restart gate that compares against the wrong count enables the driver a cycle early or late. A fault injected partway through the wake-up wait catches a design that keeps its count instead of restarting it, because such a design would drive the line long before the full wait has run from the second entry. The bench also covers both supplies bad at once, which must give host-off and not line-off. It repeats over-temperature trips in the running mode, where a design that latched the fault or forced a restart would stop driving once the flag clears.

// File: rtl/xsc_pkg.sv
package xsc_pkg;
   typedef enum logic [1:0] {
      ST_HOST_OFF = 2'd0,
      ST_LINE_OFF = 2'd1,
      ST_WAKE     = 2'd2,
      ST_RUN      = 2'd3
   } xsc_state_e;
endpackage

// File: rtl/xsc_hold_cnt.sv
// Saturating dwell counter: cleared while run is low, counts up to LIMIT.
module xsc_hold_cnt #(
   parameter int unsigned LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int unsigned CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("xsc_hold_cnt: LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run)
         cnt_q <= '0;
      else if (!done)
         cnt_q <= cnt_q + CW'(1);
   end

   assign done = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/xsc_mode_fsm.sv
module xsc_mode_fsm
   import xsc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       logic_ok,
   input  logic       bus_ok,
   input  logic       wake_done,
   output xsc_state_e state
);
   xsc_state_e nxt;

   always_comb begin
      if (!logic_ok)
         nxt = ST_HOST_OFF;
      else if (!bus_ok)
         nxt = ST_LINE_OFF;
      else begin
         unique case (state)
            ST_HOST_OFF, ST_LINE_OFF: nxt = ST_WAKE;
            ST_WAKE:                  nxt = wake_done ? ST_RUN : ST_WAKE;
            default:                  nxt = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_HOST_OFF;
      else
         state <= nxt;
   end
endmodule

// File: rtl/xsc_pin_stage.sv
module xsc_pin_stage
   import xsc_pkg::*;
(
   input  xsc_state_e state,
   input  logic       tx_bit,
   input  logic       hot,
   input  logic       bus_rx,
   input  logic       failsafe_done,
   output logic       drive_dom,
   output logic       line_float,
   output logic       rxd,
   output logic       rxd_en
);
   always_comb begin
      drive_dom  = 1'b0;
      line_float = 1'b0;
      rxd        = 1'b1;
      rxd_en     = 1'b1;
      unique case (state)
         ST_HOST_OFF: rxd_en = 1'b0;
         ST_LINE_OFF: begin
            line_float = 1'b1;
            rxd        = failsafe_done ? 1'b1 : bus_rx;
         end
         ST_WAKE: ;
         default: begin
            drive_dom = ~tx_bit & ~hot;
            rxd       = bus_rx;
         end
      endcase
   end
endmodule

// File: rtl/xcvr_safety_ctrl.sv
module xcvr_safety_ctrl
   import xsc_pkg::*;
#(
   parameter int unsigned FAILSAFE_CYC = 300,
   parameter int unsigned RECOVER_CYC  = 15000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic logic_pwr_ok,
   input  logic bus_pwr_ok,
   input  logic hot_flag,
   input  logic tx_bit,
   input  logic bus_rx_bit,
   output logic bus_drive_dom,
   output logic bus_float,
   output logic rxd_out,
   output logic rxd_oe
);
   generate
      if (FAILSAFE_CYC < 1) begin : g_chk_fs
         $error("xcvr_safety_ctrl: FAILSAFE_CYC must be at least 1");
      end
      if (RECOVER_CYC < 1) begin : g_chk_rc
         $error("xcvr_safety_ctrl: RECOVER_CYC must be at least 1");
      end
   endgenerate

   xsc_state_e state;
   logic       wake_done;
   logic       fs_done;

   xsc_mode_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .logic_ok  (logic_pwr_ok),
      .bus_ok    (bus_pwr_ok),
      .wake_done (wake_done),
      .state     (state)
   );

   xsc_hold_cnt #(.LIMIT(RECOVER_CYC)) u_wake_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == ST_WAKE),
      .done  (wake_done)
   );

   xsc_hold_cnt #(.LIMIT(FAILSAFE_CYC)) u_fs_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == ST_LINE_OFF),
      .done  (fs_done)
   );

   xsc_pin_stage u_pins (
      .state         (state),
      .tx_bit        (tx_bit),
      .hot           (hot_flag),
      .bus_rx        (bus_rx_bit),
      .failsafe_done (fs_done),
      .drive_dom     (bus_drive_dom),
      .line_float    (bus_float),
      .rxd           (rxd_out),
      .rxd_en        (rxd_oe)
   );
endmodule

// File: rtl/xsc_guard_chk.sv
module xsc_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic logic_pwr_ok,
   input logic bus_pwr_ok,
   input logic hot_flag,
   input logic tx_bit,
   input logic bus_rx_bit,
   input logic bus_drive_dom,
   input logic bus_float,
   input logic rxd_out,
   input logic rxd_oe
);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (!rxd_oe && !bus_drive_dom && !bus_float));

   assert_dom_needs_tx_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive_dom |-> !tx_bit);

   assert_rxd_low_only_on_dom_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rxd_oe && !rxd_out) |-> !bus_rx_bit);

   assert_host_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !logic_pwr_ok |=> (!rxd_oe && !bus_drive_dom && !bus_float));

   assert_line_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (logic_pwr_ok && !bus_pwr_ok) |=> (bus_float && rxd_oe && !bus_drive_dom));

   assert_hot_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hot_flag |-> !bus_drive_dom);

   assert_float_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_float |-> !bus_drive_dom);
endmodule

bind xcvr_safety_ctrl xsc_guard_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .logic_pwr_ok  (logic_pwr_ok),
   .bus_pwr_ok    (bus_pwr_ok),
   .hot_flag      (hot_flag),
   .tx_bit        (tx_bit),
   .bus_rx_bit    (bus_rx_bit),
   .bus_drive_dom (bus_drive_dom),
   .bus_float     (bus_float),
   .rxd_out       (rxd_out),
   .rxd_oe        (rxd_oe)
);

// File: tb/xcvr_safety_ctrl_tb.sv
module xcvr_safety_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int FS = 5;
   localparam int RC = 8;

   // {tx, bus_rx, hot, drive, float, rxd, oe} in running mode
   localparam logic [6:0] VEC [8] = '{
      7'b000_1001, 7'b010_1011, 7'b100_0001, 7'b110_0011,
      7'b001_0001, 7'b011_0011, 7'b101_0001, 7'b111_0011
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic logic_pwr_ok = 1'b1;
   logic bus_pwr_ok = 1'b1;
   logic hot_flag = 1'b0;
   logic tx_bit = 1'b1;
   logic bus_rx_bit = 1'b1;
   logic bus_drive_dom, bus_float, rxd_out, rxd_oe;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xcvr_safety_ctrl #(.FAILSAFE_CYC(FS), .RECOVER_CYC(RC)) u_dut (
      .clk(clk), .rst_n(rst_n), .logic_pwr_ok(logic_pwr_ok), .bus_pwr_ok(bus_pwr_ok),
      .hot_flag(hot_flag), .tx_bit(tx_bit), .bus_rx_bit(bus_rx_bit),
      .bus_drive_dom(bus_drive_dom), .bus_float(bus_float),
      .rxd_out(rxd_out), .rxd_oe(rxd_oe)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // expected order: {drive, float, rxd, oe}
   task automatic chk(input string req, input logic [3:0] exp);
      logic [3:0] act;
      #1;
      act = {bus_drive_dom, bus_float, rxd_out, rxd_oe};
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      tick(2);
      chk("R1 reset host-off", 4'b0010);
      tx_bit = 1'b0;
      bus_rx_bit = 1'b0;
      rst_n = 1'b1;
      // R7 wake-up wait after first good edge
      tick(1);
      chk("R7 wake entry", 4'b0011);
      tick(RC);
      chk("R7 wake last cycle", 4'b0011);
      tick(1);
      chk("R7 run after wait (R2 drive)", 4'b1001);

      // R2 R3 R9 table in running mode
      for (int i = 0; i < 8; i++) begin
         {tx_bit, bus_rx_bit, hot_flag} = VEC[i][6:4];
         chk($sformatf("R2 R3 R9 vector %0d", i), VEC[i][3:0]);
         tick(1);
      end

      // R9 repeated over-temperature trips
      tx_bit = 1'b0; bus_rx_bit = 1'b0; hot_flag = 1'b0;
      chk("R9 pre-trip drive", 4'b1001);
      hot_flag = 1'b1; tick(1);
      chk("R9 trip one", 4'b0001);
      hot_flag = 1'b0; tick(1);
      chk("R9 clear resumes", 4'b1001);
      hot_flag = 1'b1; tick(1);
      chk("R9 trip two", 4'b0001);
      hot_flag = 1'b0; tick(1);
      chk("R9 clear again", 4'b1001);

      // R5 R6 line-side loss
      bus_pwr_ok = 1'b0;
      tick(1);
      chk("R5 line-off entry, R6 rxd mirrors", 4'b0101);
      tick(FS - 1);
      chk("R6 last mirrored cycle", 4'b0101);
      tick(1);
      chk("R6 fail-safe high", 4'b0111);

      // R4 both bad -> host-off
      logic_pwr_ok = 1'b0;
      tick(1);
      chk("R4 both supplies bad", 4'b0010);

      // R5 host back, line still bad
      logic_pwr_ok = 1'b1;
      tick(1);
      chk("R5 line-off again", 4'b0101);

      // R8 restart of the wait
      bus_pwr_ok = 1'b1;
      tick(1);
      chk("R7 wake after line-off", 4'b0011);
      tick(3);
      logic_pwr_ok = 1'b0;
      tick(1);
      chk("R4 fault in wake", 4'b0010);
      logic_pwr_ok = 1'b1;
      tick(1);
      tick(RC);
      chk("R8 wait restarted, still waiting", 4'b0011);
      tick(1);
      chk("R8 run after full second wait", 4'b1001);

      // R4 host-side loss with line good, from running
      logic_pwr_ok = 1'b0;
      tick(1);
      chk("R4 host-off from run", 4'b0010);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule